// File: doc/BRIEF.md
# Trailing Zero Counter

This execution unit reports how many consecutive zero bits sit at the bottom of a source operand, starting at bit 0. The operand is 64 bits wide, but a two-bit size code restricts the count to the low 16, 32 or 64 bits. Bits above the selected size are ignored. When the selected bits are all zero, the count equals the operand size. A carry flag and a zero flag are derived from the count. Four further arithmetic flags, which have no defined meaning for this operation, are driven low.

A compatibility mode reproduces the older forward bit-scan behaviour. In that mode, a zero source does not produce a count. Instead, the destination keeps the value supplied on a previous-destination input, the zero flag is raised and the carry flag is cleared.

The count comes from a log-depth priority tree, so the whole result settles within one cycle. An output register stage is on by default. It captures a result whenever an input is marked valid and raises the output valid one cycle later.

Top module: `tz_count_unit`

## Requirements
- R1: The count equals the index of the lowest set bit within the selected operand size.
- R2: Source bits at or above the selected size have no effect on the count or on the flags.
- R3: The size code is 00 for 16 bits, 01 for 32 bits, 10 for 64 bits and 11 for 64 bits. When every selected bit is zero, the count equals 16, 32 or 64 respectively.
- R4: Outside compatibility mode, `flag_c` is 1 exactly when the count equals the operand size.
- R5: Outside the compatibility zero case, `flag_z` is 1 exactly when the count is zero, which is the case when source bit 0 is set.
- R6: `other_flags` (overflow, sign, parity, adjust, in bits 3 down to 0) is always 0.
- R7: In compatibility mode with all selected bits zero, `result` equals `prev_dest`, `flag_z` is 1 and `flag_c` is 0.
- R8: In compatibility mode with a nonzero selected source, `result` and both flags match the counting mode.
- R9: Outside the compatibility zero case, `result` is zero-extended, so bits 63 down to 7 are 0.
- R10: With the register stage present, `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source operand is valid this cycle |
| src | input | 64 | Source operand |
| op_size | input | 2 | Size code: 00=16, 01=32, 1x=64 |
| legacy_scan | input | 1 | Compatibility forward-scan mode |
| prev_dest | input | 64 | Destination value kept on a zero source in compatibility mode |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 64 | Zero-extended count, or `prev_dest` in the compatibility zero case |
| flag_c | output | 1 | Carry: the selected source was zero |
| flag_z | output | 1 | Zero: the count is zero |
| other_flags | output | 4 | Flags with no defined meaning, held at 0 |

## Verification
Each size is driven with a single walking set bit on top of random garbage in the higher bits. This separates a correct lowest-set-bit search from one that picks the wrong end or the wrong tree half. Operands whose only set bits lie just above the size boundary check that the mask is applied before the search. Exact zeros under every size code, including code 11, confirm the size-valued result and the carry flag. The same boundary operands are then repeated in compatibility mode, which distinguishes the kept previous destination from a counted size.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
  localparam int DATA_W = 64;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int CNT_W  = IDX_W + 1;

  typedef enum logic [1:0] {
    SZ16  = 2'b00,
    SZ32  = 2'b01,
    SZ64  = 2'b10,
    SZ64X = 2'b11
  } opsize_e;

  // number of operand bits selected by a size code
  function automatic logic [CNT_W-1:0] size_bits(opsize_e s);
    case (s)
      SZ16:    return CNT_W'(16);
      SZ32:    return CNT_W'(32);
      default: return CNT_W'(DATA_W);
    endcase
  endfunction

  // mask of the bits that take part in the count
  function automatic logic [DATA_W-1:0] size_mask(opsize_e s);
    logic [DATA_W-1:0] ones;
    ones = '1;
    return ones >> (DATA_W - int'(size_bits(s)));
  endfunction
endpackage

// File: rtl/tz_prio_tree.sv
module tz_prio_tree #(
  parameter int W = 64,
  localparam int LW = $clog2(W),
  localparam int LV = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic          found,
  output logic [LW-1:0] first_idx
);
  for (genvar k = 0; k <= LV; k++) begin : g_lvl
    localparam int N = W >> k;
    logic [N-1:0]    any;
    logic [N*LW-1:0] idx;
    if (k == 0) begin : g_leaf
      assign any = bits;
      assign idx = '0;
    end else begin : g_node
      for (genvar j = 0; j < N; j++) begin : g_pair
        logic lo_any, hi_any;
        logic [LW-1:0] lo_idx, hi_idx;
        assign lo_any = g_lvl[k-1].any[2*j];
        assign hi_any = g_lvl[k-1].any[2*j+1];
        assign lo_idx = g_lvl[k-1].idx[(2*j)*LW +: LW];
        assign hi_idx = g_lvl[k-1].idx[(2*j+1)*LW +: LW];
        assign any[j] = lo_any | hi_any;
        assign idx[j*LW +: LW] = lo_any ? lo_idx
                                        : (hi_idx | LW'(1 << (k-1)));
      end
    end
  end

  assign found     = g_lvl[LV].any[0];
  assign first_idx = g_lvl[LV].idx[LW-1:0];
endmodule

// File: rtl/tz_result.sv
module tz_result
  import tzc_pkg::*;
(
  input  logic [DATA_W-1:0] src,
  input  opsize_e           size,
  input  logic              legacy,
  input  logic [DATA_W-1:0] prev,
  output logic [DATA_W-1:0] result,
  output logic              cf,
  output logic              zf,
  output logic              legacy_hit
);
  logic [DATA_W-1:0] sel_bits;
  logic              found;
  logic [IDX_W-1:0]  first_idx;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  op_bits;

  assign op_bits  = size_bits(size);
  assign sel_bits = src & size_mask(size);

  tz_prio_tree #(.W(DATA_W)) u_tree (
    .bits      (sel_bits),
    .found     (found),
    .first_idx (first_idx)
  );

  assign cnt        = found ? {1'b0, first_idx} : op_bits;
  assign legacy_hit = legacy & ~found;

  always_comb begin
    if (legacy_hit) begin
      result = prev;
      cf     = 1'b0;
      zf     = 1'b1;
    end else begin
      result = {{(DATA_W-CNT_W){1'b0}}, cnt};
      cf     = ~found;
      zf     = (cnt == '0);
    end
  end
endmodule

// File: rtl/tz_count_unit.sv
module tz_count_unit
  import tzc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src,
  input  logic [1:0]        op_size,
  input  logic              legacy_scan,
  input  logic [DATA_W-1:0] prev_dest,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_z,
  output logic [3:0]        other_flags
);
  logic [DATA_W-1:0] res_c;
  logic              cf_c, zf_c, hit_c;
  logic              hit_out;

  tz_result u_res (
    .src        (src),
    .size       (opsize_e'(op_size)),
    .legacy     (legacy_scan),
    .prev       (prev_dest),
    .result     (res_c),
    .cf         (cf_c),
    .zf         (zf_c),
    .legacy_hit (hit_c)
  );

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] res_q;
    logic              cf_q, zf_q, hit_q, vld_q;
    always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_c;
        cf_q  <= cf_c;
        zf_q  <= zf_c;
        hit_q <= hit_c;
      end
    end
    assign out_valid = vld_q;
    assign result    = res_q;
    assign flag_c    = cf_q;
    assign flag_z    = zf_q;
    assign hit_out   = hit_q;
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = res_c;
    assign flag_c    = cf_c;
    assign flag_z    = zf_c;
    assign hit_out   = hit_c;
  end

  assign other_flags = 4'b0000;
endmodule

// File: rtl/tz_count_chk.sv
module tz_count_chk
  import tzc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_c,
  input logic              flag_z,
  input logic              legacy_hit
);
  if (REG_OUT) begin : g_pipe
    // R10
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R10
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R10
    vld_reset_chk: assert property (@(posedge clk)
      rst |=> !out_valid);
  end

  // R4
  carry_size_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_c) |->
      (!flag_z && (result == 64'd16 || result == 64'd32 || result == 64'(DATA_W))));
  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !legacy_hit) |-> (flag_z == (result == '0)));
  // R7
  legacy_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && legacy_hit) |-> (flag_z && !flag_c));
  // R9
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !legacy_hit) |-> (result[DATA_W-1:CNT_W] == '0));
endmodule

bind tz_count_unit tz_count_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .result     (result),
  .flag_c     (flag_c),
  .flag_z     (flag_z),
  .legacy_hit (hit_out)
);

// File: tb/test_tz_count_unit.sv
`timescale 1ns/1ps
module test_tz_count_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] src;
  logic [1:0]  op_size;
  logic        legacy_scan;
  logic [63:0] prev_dest;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_c, flag_z;
  logic [3:0]  other_flags;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  typedef struct packed {
    logic [63:0] res;
    logic        c;
    logic        z;
    logic [15:0] tag;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  tz_count_unit i_tz_count_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
    .op_size(op_size), .legacy_scan(legacy_scan), .prev_dest(prev_dest),
    .out_valid(out_valid), .result(result), .flag_c(flag_c),
    .flag_z(flag_z), .other_flags(other_flags)
  );

  // reference: walk upward bit by bit
  function automatic exp_t model(logic [63:0] s, logic [1:0] sz, logic leg,
                                 logic [63:0] pv, logic [15:0] tag);
    exp_t e;
    int n;
    int c;
    n = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
    c = 0;
    while (c < n && s[c] == 1'b0) c++;
    e.tag = tag;
    if (leg && c == n) begin
      e.res = pv; e.c = 1'b0; e.z = 1'b1;
    end else begin
      e.res = 64'(c); e.c = (c == n); e.z = (c == 0);
    end
    return e;
  endfunction

  task automatic check(logic ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] s, logic [1:0] sz, logic leg,
                       logic [63:0] pv, logic [15:0] tag);
    @(negedge clk);
    in_valid = 1'b1; src = s; op_size = sz; legacy_scan = leg; prev_dest = pv;
    sb.push_back(model(s, sz, leg, pv, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src = 64'hFFFF_FFFF_FFFF_FFFF;
    end
  endtask

  // monitor: compare results as they appear
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10 unexpected out_valid", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(result == e.res, string'(e.tag), result, e.res);
          check({flag_c, flag_z} == {e.c, e.z}, string'(e.tag),
                {62'd0, flag_c, flag_z}, {62'd0, e.c, e.z});
          check(other_flags == 4'b0000, "R6", {60'd0, other_flags}, 64'd0);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        check(1'b0, "watchdog", 64'(cycles), 64'd20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; src = '0; op_size = 2'b10;
    legacy_scan = 1'b0; prev_dest = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 reset", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 basic counts
    drive(64'h1, 2'b10, 1'b0, 0, "R5");
    drive(64'h8, 2'b10, 1'b0, 0, "R1");
    drive(64'h8000_0000_0000_0000, 2'b10, 1'b0, 0, "R1");
    drive(64'h100, 2'b00, 1'b0, 0, "R1");
    drive(64'h0000_0000_0000_8000, 2'b00, 1'b0, 0, "R1");
    // R2 bits above the size are ignored
    drive(64'hFFFF_FFFF_FFFF_0000, 2'b00, 1'b0, 0, "R2");
    drive(64'h0000_0001_0000_0000, 2'b01, 1'b0, 0, "R2");
    drive(64'hA000_0000_0004_0000, 2'b01, 1'b0, 0, "R2");
    // R3 zero source per size code; R4 carry
    drive(64'h0, 2'b00, 1'b0, 0, "R3");
    drive(64'h0, 2'b01, 1'b0, 0, "R3");
    drive(64'h0, 2'b10, 1'b0, 0, "R4");
    drive(64'h0, 2'b11, 1'b0, 0, "R3");
    // R7 compatibility zero case
    drive(64'h0, 2'b10, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, "R7");
    drive(64'h0001_0000, 2'b00, 1'b1, 64'h1234_5678_9ABC_DEF0, "R7");
    drive(64'h0, 2'b01, 1'b1, 64'h0, "R7");
    // R8 compatibility nonzero
    drive(64'h40, 2'b10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    drive(64'h8000, 2'b00, 1'b1, 64'h5555, "R8");
    drive(64'h1, 2'b01, 1'b1, 64'h77, "R8");
    idle(3);
    check(sb.size() == 0, "R10 drained", 64'(sb.size()), 64'd0);

    // R9 walking bit with random garbage above it, every size
    for (int sz = 0; sz < 4; sz++) begin
      for (int i = 0; i < 64; i++) begin
        logic [63:0] g;
        g = {$urandom, $urandom};
        drive((g << i) | (64'd1 << i), 2'(sz), 1'(i % 2), 64'hFEED, "R9");
      end
    end
    idle(2);
    // R10 valid gaps
    drive(64'h20, 2'b10, 1'b0, 0, "R10");
    idle(2);
    drive(64'h400, 2'b01, 1'b0, 0, "R10");
    idle(3);
    #1;
    check(out_valid == 1'b0, "R10 idle", {63'd0, out_valid}, 64'd0);
    check(sb.size() == 0, "R10 drained", 64'(sb.size()), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule